// File: doc/BRIEF.md
# Tagged Branch Direction Predictor

This block guesses whether a fetched branch will be taken. It looks the guess up in a direct-mapped table of 64 entries. The table is addressed by the fetch address alone, so the lookup can run in the same cycle as the instruction cache read. Each entry keeps a small tag and a saturating up/down counter.

When the stored tag matches the fetch address, the top bit of the counter gives the guess. When it does not match, or the entry has never been trained, a static rule applies instead. The rule looks at the sign of the decoded branch offset: a branch that jumps backwards is guessed taken, and one that jumps forwards is guessed not taken.

A separate update port trains the table once the branch has resolved. On an update that hits, the counter steps up or down. On an update that misses, the entry is claimed for the new branch.

Top module: `branch_dir_pred`

## Requirements
- R1: The entry index is PC[7:2] and the tag is PC[11:8]. Addresses that differ only in bits 1:0 or in bits above 11 share one entry and one prediction. Addresses that differ in bits 11:8 but share bits 7:2 compete for the same entry.
- R2: A lookup is combinational. `pred_hit` is 1 in the same cycle when the indexed entry is valid and its stored tag equals the tag of `lk_pc`.
- R3: On an update that hits, the counter of the entry increments when `up_taken` is 1 and decrements when it is 0. It saturates at its maximum value and at 0.
- R4: With the default 2-bit counter, counter values 2 and 3 predict taken, and values 0 and 1 predict not taken.
- R5: An update that misses allocates the entry. It writes the new tag, replacing any other branch held there, and sets the counter to weakly taken (2) if taken or weakly not taken (1) otherwise. The entry hits from the next cycle.
- R6: On a lookup miss, `pred_taken` equals `lk_off_neg`: a negative offset is predicted taken and a non-negative offset is predicted not taken.
- R7: Synchronous active-low reset invalidates every entry, so all lookups miss until an entry is trained again.
- R8: When an update and a lookup address the same entry in the same cycle, the lookup returns the state from before the update. The new state is visible from the next cycle.
- R9: With CNT_W = 1, a hitting entry predicts the outcome of the last update made to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | ADDR_W | Fetch address to predict |
| lk_off_neg | input | 1 | Sign of the decoded branch offset (1 = backward) |
| up_valid | input | 1 | A resolved branch is presented for training |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome (1 = taken) |
| pred_hit | output | 1 | Lookup found a valid entry with a matching tag |
| pred_taken | output | 1 | Predicted direction (1 = taken) |

## Verification
A wrong counter value shows up only as a wrong `pred_taken` on a hitting lookup. It can stay hidden for several updates, because values on the same side of the threshold give the same prediction. The bench therefore walks each counter through both saturation ends and through the hysteresis step, and checks the prediction after every single update.

A corrupted tag or valid bit shows up at once as a wrong `pred_hit`, in the first lookup cycle after the faulty write. An aliasing address and a reset replay make such errors visible. A same-cycle update and lookup shows whether the table reads its old state or its new state.

// File: rtl/bdp_pkg.sv
// Package for the branch direction predictor.
// Holds the action code chosen by the update path.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package bdp_pkg;
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_TRAIN = 2'd1,
        UPD_ALLOC = 2'd2
    } upd_act_e;
endpackage

// File: rtl/bdp_addr_split.sv
// Splits an instruction address into a table index and a partial tag.
// Assumes: IDX_LSB + IDX_W + TAG_W <= ADDR_W.
module bdp_addr_split #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 4
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int TAG_LSB = IDX_LSB + IDX_W;

    logic unused_pc_bits;

    // Field extraction: the index sits above the alignment bits,
    // and the tag sits directly above the index.
    always_comb begin
        idx            = pc[TAG_LSB-1:IDX_LSB];
        tag            = pc[TAG_LSB+TAG_W-1:TAG_LSB];
        unused_pc_bits = ^{pc[ADDR_W-1:TAG_LSB+TAG_W], pc[IDX_LSB-1:0]};
    end
endmodule

// File: rtl/bdp_ctr_next.sv
// Next-state logic for one saturating up/down direction counter.
// Allocation loads the weak state on the side of the outcome.
// Assumes: CNT_W >= 1.
module bdp_ctr_next #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             taken,
    input  logic             alloc,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] WEAK_T  = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] WEAK_NT = WEAK_T - CNT_W'(1);

    // Counter step: load on allocation, otherwise step with saturation.
    always_comb begin
        if (alloc)
            nxt = taken ? WEAK_T : WEAK_NT;
        else if (taken && cur != CNT_MAX)
            nxt = cur + CNT_W'(1);
        else if (!taken && cur != '0)
            nxt = cur - CNT_W'(1);
        else
            nxt = cur;
    end
endmodule

// File: rtl/bdp_table.sv
// Direct-mapped entry storage.
// Two asynchronous read ports (lookup and update) and one write port.
// Assumes: reads see the stored state before the current edge's write.
// Only the valid bits are reset; tags and counters are written on allocation.
module bdp_table #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output logic             ra_valid,
    output logic [TAG_W-1:0] ra_tag,
    output logic [CNT_W-1:0] ra_cnt,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_valid,
    output logic [TAG_W-1:0] rb_tag,
    output logic [CNT_W-1:0] rb_cnt,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [CNT_W-1:0] wr_cnt
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld;
    logic [TAG_W-1:0] tags [DEPTH];
    logic [CNT_W-1:0] cnts [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Per-entry state: valid is cleared by reset and set on any write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[e] <= 1'b0;
            end else if (we && wr_idx == IDX_W'(e)) begin
                vld[e]  <= 1'b1;
                tags[e] <= wr_tag;
                cnts[e] <= wr_cnt;
            end
        end
    end

    // Read ports: combinational reads of the registered state.
    always_comb begin
        ra_valid = vld[ra_idx];
        ra_tag   = tags[ra_idx];
        ra_cnt   = cnts[ra_idx];
        rb_valid = vld[rb_idx];
        rb_tag   = tags[rb_idx];
        rb_cnt   = cnts[rb_idx];
    end
endmodule

// File: rtl/branch_dir_pred.sv
// Tagged branch direction predictor.
// A lookup is combinational from the fetch address. On a hit the counter's
// top bit is the guess; on a miss the sign of the branch offset decides.
// Updates train a hitting entry or allocate a missing one.
// Assumes: one update per cycle at most; the offset sign arrives with lk_pc.
module branch_dir_pred #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 4,
    parameter int CNT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic              lk_off_neg,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    output logic              pred_hit,
    output logic              pred_taken
);
    import bdp_pkg::*;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             ra_valid, rb_valid;
    logic [TAG_W-1:0] ra_tag, rb_tag;
    logic [CNT_W-1:0] ra_cnt, rb_cnt, new_cnt;
    logic             up_hit;
    upd_act_e         act;

    bdp_addr_split #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
        u_lk_split (.pc(lk_pc), .idx(lk_idx), .tag(lk_tag));

    bdp_addr_split #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
        u_up_split (.pc(up_pc), .idx(up_idx), .tag(up_tag));

    bdp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(lk_idx), .ra_valid(ra_valid), .ra_tag(ra_tag), .ra_cnt(ra_cnt),
        .rb_idx(up_idx), .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_cnt(rb_cnt),
        .we(act != UPD_IDLE), .wr_idx(up_idx), .wr_tag(up_tag), .wr_cnt(new_cnt)
    );

    // Lookup: tag check, then counter threshold or static offset rule.
    always_comb begin
        pred_hit   = ra_valid && (ra_tag == lk_tag);
        pred_taken = pred_hit ? ra_cnt[CNT_W-1] : lk_off_neg;
    end

    // Update decision: train on a tag hit, allocate on a miss.
    always_comb begin
        up_hit = rb_valid && (rb_tag == up_tag);
        if (!up_valid)
            act = UPD_IDLE;
        else if (up_hit)
            act = UPD_TRAIN;
        else
            act = UPD_ALLOC;
    end

    bdp_ctr_next #(.CNT_W(CNT_W)) u_ctr (
        .cur(rb_cnt), .taken(up_taken), .alloc(act == UPD_ALLOC), .nxt(new_cnt)
    );
endmodule

// File: rtl/bdp_checker.sv
// Port-level properties of the branch direction predictor.
// Attached to every instance of the top through bind.
module bdp_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              lk_off_neg,
    input logic              up_valid,
    input logic [ADDR_W-1:0] up_pc,
    input logic              up_taken,
    input logic              pred_hit,
    input logic              pred_taken
);
    logic rst_q;

    // Reset history: low in the first cycle after reset is released.
    always_ff @(posedge clk) rst_q <= rst_n;

    assert_miss_static_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> pred_taken == lk_off_neg);

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_q |-> !pred_hit);

    assert_alloc_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_valid) && lk_pc == $past(up_pc)) |-> pred_hit);

    assert_taken_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_valid && up_taken && pred_hit && pred_taken
                              && lk_pc == up_pc) && $stable(lk_pc))
        |-> (pred_hit && pred_taken));

    assert_nt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_valid && !up_taken && pred_hit && !pred_taken
                              && lk_pc == up_pc) && $stable(lk_pc))
        |-> (pred_hit && !pred_taken));
endmodule

bind branch_dir_pred bdp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_off_neg(lk_off_neg),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .pred_hit(pred_hit), .pred_taken(pred_taken)
);

// File: tb/branch_dir_pred_tb.sv
module branch_dir_pred_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PC_A    = 32'h0000_1234; // index 13, tag 2
    localparam logic [31:0] PC_B    = 32'h0000_1334; // index 13, tag 3
    localparam logic [31:0] PC_A_HI = 32'h1000_1234; // differs above bit 11
    localparam logic [31:0] PC_A_LO = 32'h0000_1237; // differs in bits 1:0
    localparam logic [31:0] PC_C    = 32'h0000_0040; // index 16, tag 0

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_off_neg = 1'b0;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic        hit2, tk2, hit1, tk1;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_dir_pred u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_off_neg(lk_off_neg),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .pred_hit(hit2), .pred_taken(tk2)
    );

    branch_dir_pred #(.CNT_W(1)) u_dut_1b (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_off_neg(lk_off_neg),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .pred_hit(hit1), .pred_taken(tk1)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Present a lookup after a falling edge and let it settle.
    task automatic look(input logic [31:0] pc, input logic neg);
        @(negedge clk);
        lk_pc = pc;
        lk_off_neg = neg;
        #1;
    endtask

    // One update, written at the next rising edge.
    task automatic train(input logic [31:0] pc, input logic tk);
        @(negedge clk);
        up_valid = 1'b1;
        up_pc = pc;
        up_taken = tk;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_and_static();
        do_reset();
        look(PC_A, 1'b0);
        check("R7", "hit after reset", hit2, 1'b0);
        check("R6", "forward miss", tk2, 1'b0);
        look(PC_A, 1'b1);
        check("R6", "backward miss", tk2, 1'b1);
        look(PC_C, 1'b1);
        check("R2", "untrained hit", hit2, 1'b0);
    endtask

    task automatic t_counter_walk();
        train(PC_A, 1'b1);                      // allocate -> 2
        look(PC_A, 1'b0);
        check("R5", "alloc hit", hit2, 1'b1);
        check("R5", "alloc taken weak", tk2, 1'b1);
        train(PC_A, 1'b0); look(PC_A, 1'b0);    // 1
        check("R4", "cnt1 nt", tk2, 1'b0);
        train(PC_A, 1'b0); train(PC_A, 1'b0);   // 0, stays 0
        train(PC_A, 1'b1); look(PC_A, 1'b0);    // 1
        check("R3", "low saturation", tk2, 1'b0);
        train(PC_A, 1'b1); look(PC_A, 1'b0);    // 2
        check("R4", "cnt2 taken", tk2, 1'b1);
        train(PC_A, 1'b1); train(PC_A, 1'b1);   // 3, stays 3
        train(PC_A, 1'b0); look(PC_A, 1'b1);    // 2
        check("R3", "high saturation", tk2, 1'b1);
        train(PC_A, 1'b0); look(PC_A, 1'b1);    // 1
        check("R4", "cnt1 overrides backward offset", tk2, 1'b0);
        check("R2", "trained hit", hit2, 1'b1);
    endtask

    task automatic t_alias();
        look(PC_A_HI, 1'b1);
        check("R1", "high bits ignored hit", hit2, 1'b1);
        check("R1", "high bits ignored pred", tk2, 1'b0);
        look(PC_A_LO, 1'b1);
        check("R1", "low bits ignored", hit2, 1'b1);
        look(PC_B, 1'b1);
        check("R1", "tag mismatch miss", hit2, 1'b0);
        check("R6", "tag mismatch static", tk2, 1'b1);
        train(PC_B, 1'b0);                      // replace with weak NT
        look(PC_B, 1'b1);
        check("R5", "replaced hit", hit2, 1'b1);
        check("R5", "replaced weak nt", tk2, 1'b0);
        look(PC_A, 1'b1);
        check("R5", "old tag evicted", hit2, 1'b0);
    endtask

    task automatic t_same_cycle();
        train(PC_C, 1'b0);                      // cnt 1
        @(negedge clk);
        lk_pc = PC_C; lk_off_neg = 1'b0;
        up_valid = 1'b1; up_pc = PC_C; up_taken = 1'b1;
        #1;
        check("R8", "same cycle old value", tk2, 1'b0);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        check("R8", "next cycle new value", tk2, 1'b1);
    endtask

    task automatic t_one_bit();
        do_reset();
        train(PC_A, 1'b1); look(PC_A, 1'b0);
        check("R9", "1b alloc taken", tk1, 1'b1);
        train(PC_A, 1'b0); look(PC_A, 1'b1);
        check("R9", "1b last nt", tk1, 1'b0);
        train(PC_A, 1'b1); look(PC_A, 1'b0);
        check("R9", "1b last taken", tk1, 1'b1);
        check("R7", "2b after second reset hits", hit2, 1'b1);
        look(PC_B, 1'b0);
        check("R7", "reset cleared replaced entry", hit2, 1'b0);
    endtask

    initial begin
        t_reset_and_static();
        t_counter_walk();
        t_alias();
        t_same_cycle();
        t_one_bit();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule